// File: doc/BRIEF.md
# Pin Function Multiplexer with Crossbar

This block connects a small set of chip pins to peripheral signals. Each pin has a registered function selector. A low selector value ties the pin to one fixed peripheral signal that depends on the pin's position. A higher band of selector values reaches every peripheral signal through a full crossbar, so any pin can serve any signal. The selected peripheral output drives the pad output and the pad output-enable. When the selected signal is a peripheral input, the pad value is routed back to that input.

Two pins carry the serial-wire debug clock and data after reset. While the debug lock is set, writes to their selectors have no effect. Clearing the lock through a control address hands both pins back to the multiplexer. A status flag then reports which debug pin was reassigned and the selector it received. Each peripheral input that no pin claims sits at a defined idle level. When several pins claim the same input, the lowest-numbered pin drives it.

Top module: `pinmux_xbar`

## Requirements
- R1: After reset all selectors are 0, the debug lock is set, the taken flag is clear, every pad output-enable is low except the debug data pin (which follows the debug side), and every peripheral input is at its idle level.
- R2: Selector values 0, 3 to 15 and 24 to 63 leave the pad with output-enable and output both low, and claim no peripheral input.
- R3: Selector 1 makes pin p feed peripheral input index (p mod NUM_IN), with output-enable low; on pin 1 this is the second UART receive input (index 1).
- R4: Selector 2 makes pin p drive the value and output-enable of peripheral output index (p mod NUM_OUT).
- R5: Selectors 16 to 19 drive the pad from peripheral output index (selector minus 16); selector 19 is the first UART transmit output (index 3).
- R6: Selectors 20 to 23 route the pad to peripheral input index (selector minus 20), with output-enable low; selector 20 is the first UART receive input (index 0).
- R7: An unclaimed peripheral input reads its idle level: 1 for indices 0 and 1 (UART receive), 0 for indices 2 and 3.
- R8: When more than one pin claims a peripheral input, through either selector band, the input takes the pad value of the lowest-numbered claiming pin.
- R9: A pad output is 0 whenever its output-enable is 0.
- R10: While the lock is set, pin 6 is an input whose value appears on the debug clock output, pin 7 carries the debug data output and enable and returns its pad value to the debug data input, and writes to the selectors of pins 6 and 7 are ignored.
- R11: A write to address 8 sets the lock to bit 0 of the data. While the lock is clear, pins 6 and 7 follow their selectors, the debug clock input reads 0 and the debug data input reads 1.
- R12: A nonzero selector written to pin 6 or 7 while the lock is clear sets the taken flag and records the pin (0 for pin 6, 1 for pin 7) and the selector. A write that sets the lock clears the flag.
- R13: Selector writes take effect in the cycle after the write. Writes to addresses 9 to 15 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address: 0..7 pin selectors, 8 control |
| wr_data_i | input | 6 | Write data |
| pad_in_i | input | 8 | Pad input values |
| pad_out_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables |
| per_out_i | input | 4 | Peripheral output signals |
| per_oe_i | input | 4 | Peripheral output enables |
| per_in_o | output | 4 | Peripheral input signals |
| swd_dio_i | input | 1 | Debug data toward the pad |
| swd_dio_oe_i | input | 1 | Debug data output enable |
| swd_clk_o | output | 1 | Debug clock from the pad |
| swd_dio_o | output | 1 | Debug data from the pad |
| dbg_lock_o | output | 1 | Debug lock state |
| dbg_taken_o | output | 1 | A debug pin was reassigned |
| dbg_taken_pin_o | output | 1 | Which debug pin: 0 clock, 1 data |
| dbg_taken_fid_o | output | 6 | Selector given to that pin |

## Verification
The bench uses the default parameters: eight pins, four peripheral outputs, four peripheral inputs, a crossbar band starting at 16, and debug pins 6 and 7. With these values, selectors 19 and 20 land on the first UART transmit and receive signals, and pins 4 and 5 wrap the dedicated index modulo four. Pins 1 and 4 can therefore collide on the same input through either band. The 4-bit address also leaves 9 to 15 free, which the bench uses to probe the writes that must be ignored.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  // dedicated-band selector codes
  localparam int unsigned DED_RX_ID = 1;
  localparam int unsigned DED_TX_ID = 2;
  localparam int unsigned DED_END   = 2;
endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs #(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned FID_W       = 6,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DBG_CLK_PIN = 6,
  parameter int unsigned DBG_DAT_PIN = 7
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_en_i,
  input  logic [ADDR_W-1:0]                  wr_addr_i,
  input  logic [FID_W-1:0]                   wr_data_i,
  output logic [NUM_PINS-1:0][FID_W-1:0]     fid_o,
  output logic                               lock_o,
  output logic                               taken_o,
  output logic                               taken_pin_o,
  output logic [FID_W-1:0]                   taken_fid_o
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_PINS);
  localparam logic [ADDR_W-1:0] CLK_ADDR  = ADDR_W'(DBG_CLK_PIN);
  localparam logic [ADDR_W-1:0] DAT_ADDR  = ADDR_W'(DBG_DAT_PIN);

  logic lock_q;
  logic dbg_wr;

  assign dbg_wr = wr_en_i && (wr_addr_i == CLK_ADDR || wr_addr_i == DAT_ADDR);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_fid
    localparam bit IS_DBG = (p == DBG_CLK_PIN) || (p == DBG_DAT_PIN);
    logic [FID_W-1:0] fid_q;
    logic             wr_hit;
    if (IS_DBG) begin : g_dbg
      assign wr_hit = wr_en_i && (wr_addr_i == ADDR_W'(p)) && !lock_q;
    end else begin : g_plain
      assign wr_hit = wr_en_i && (wr_addr_i == ADDR_W'(p));
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     fid_q <= '0;
      else if (wr_hit) fid_q <= wr_data_i;
    end
    assign fid_o[p] = fid_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b1;
    else if (wr_en_i && wr_addr_i == CTRL_ADDR) lock_q <= wr_data_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o     <= 1'b0;
      taken_pin_o <= 1'b0;
      taken_fid_o <= '0;
    end else if (wr_en_i && wr_addr_i == CTRL_ADDR && wr_data_i[0]) begin
      taken_o <= 1'b0;
    end else if (dbg_wr && !lock_q && wr_data_i != '0) begin
      taken_o     <= 1'b1;
      taken_pin_o <= (wr_addr_i == DAT_ADDR);
      taken_fid_o <= wr_data_i;
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/pinmux_pin_route.sv
module pinmux_pin_route
  import pinmux_pkg::*;
#(
  parameter int unsigned PIN_IDX  = 0,
  parameter int unsigned NUM_OUT  = 4,
  parameter int unsigned NUM_IN   = 4,
  parameter int unsigned FID_W    = 6,
  parameter int unsigned FM_START = 16
) (
  input  logic [FID_W-1:0]   fid_i,
  input  logic [NUM_OUT-1:0] per_out_i,
  input  logic [NUM_OUT-1:0] per_oe_i,
  input  logic               force_en_i,
  input  logic               force_out_i,
  input  logic               force_oe_i,
  output logic               pad_out_o,
  output logic               pad_oe_o,
  output logic [NUM_IN-1:0]  in_req_o
);
  localparam int unsigned DED_IN  = PIN_IDX % NUM_IN;
  localparam int unsigned DED_OUT = PIN_IDX % NUM_OUT;
  localparam int unsigned FM_IN   = FM_START + NUM_OUT;

  logic drv, oe;
  logic [NUM_IN-1:0] req;

  always_comb begin
    drv = 1'b0;
    oe  = 1'b0;
    req = '0;
    if (fid_i == FID_W'(DED_RX_ID)) req[DED_IN] = 1'b1;
    if (fid_i == FID_W'(DED_TX_ID)) begin
      drv = per_out_i[DED_OUT];
      oe  = per_oe_i[DED_OUT];
    end
    for (int o = 0; o < NUM_OUT; o++) begin
      if (fid_i == FID_W'(FM_START + o)) begin
        drv = per_out_i[o];
        oe  = per_oe_i[o];
      end
    end
    for (int i = 0; i < NUM_IN; i++) begin
      if (fid_i == FID_W'(FM_IN + i)) req[i] = 1'b1;
    end
    if (force_en_i) begin
      req = '0;
      drv = force_out_i;
      oe  = force_oe_i;
    end
  end

  assign pad_oe_o  = oe;
  assign pad_out_o = drv & oe;
  assign in_req_o  = req;
endmodule

// File: rtl/pinmux_in_arb.sv
module pinmux_in_arb #(
  parameter int unsigned       NUM_PINS = 8,
  parameter int unsigned       NUM_IN   = 4,
  parameter logic [NUM_IN-1:0] IN_IDLE  = '0
) (
  input  logic [NUM_PINS-1:0][NUM_IN-1:0] req_i,
  input  logic [NUM_PINS-1:0]             pad_in_i,
  output logic [NUM_IN-1:0]               per_in_o
);
  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    logic val;
    // scan from the top so the lowest claiming pin is assigned last
    always_comb begin
      val = IN_IDLE[i];
      for (int p = NUM_PINS - 1; p >= 0; p--) begin
        if (req_i[p][i]) val = pad_in_i[p];
      end
    end
    assign per_in_o[i] = val;
  end
endmodule

// File: rtl/pinmux_xbar.sv
module pinmux_xbar #(
  parameter int unsigned       NUM_PINS    = 8,
  parameter int unsigned       NUM_OUT     = 4,
  parameter int unsigned       NUM_IN      = 4,
  parameter int unsigned       FID_W       = 6,
  parameter int unsigned       FM_START    = 16,
  parameter int unsigned       DBG_CLK_PIN = 6,
  parameter int unsigned       DBG_DAT_PIN = 7,
  parameter logic [NUM_IN-1:0] IN_IDLE     = 4'b0011,
  localparam int unsigned      ADDR_W      = $clog2(NUM_PINS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [FID_W-1:0]    wr_data_i,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  input  logic [NUM_OUT-1:0]  per_out_i,
  input  logic [NUM_OUT-1:0]  per_oe_i,
  output logic [NUM_IN-1:0]   per_in_o,
  input  logic                swd_dio_i,
  input  logic                swd_dio_oe_i,
  output logic                swd_clk_o,
  output logic                swd_dio_o,
  output logic                dbg_lock_o,
  output logic                dbg_taken_o,
  output logic                dbg_taken_pin_o,
  output logic [FID_W-1:0]    dbg_taken_fid_o
);
  logic [NUM_PINS-1:0][FID_W-1:0]  fid_q;
  logic [NUM_PINS-1:0][NUM_IN-1:0] in_req;
  logic                            lock;

  pinmux_regs #(
    .NUM_PINS(NUM_PINS), .FID_W(FID_W), .ADDR_W(ADDR_W),
    .DBG_CLK_PIN(DBG_CLK_PIN), .DBG_DAT_PIN(DBG_DAT_PIN)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .fid_o(fid_q), .lock_o(lock), .taken_o(dbg_taken_o),
    .taken_pin_o(dbg_taken_pin_o), .taken_fid_o(dbg_taken_fid_o)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic f_en, f_out, f_oe;
    if (p == DBG_DAT_PIN) begin : g_dat
      assign f_en  = lock;
      assign f_out = swd_dio_i;
      assign f_oe  = swd_dio_oe_i;
    end else if (p == DBG_CLK_PIN) begin : g_clk
      assign f_en  = lock;
      assign f_out = 1'b0;
      assign f_oe  = 1'b0;
    end else begin : g_norm
      assign f_en  = 1'b0;
      assign f_out = 1'b0;
      assign f_oe  = 1'b0;
    end
    pinmux_pin_route #(
      .PIN_IDX(p), .NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN),
      .FID_W(FID_W), .FM_START(FM_START)
    ) u_route (
      .fid_i(fid_q[p]), .per_out_i, .per_oe_i,
      .force_en_i(f_en), .force_out_i(f_out), .force_oe_i(f_oe),
      .pad_out_o(pad_out_o[p]), .pad_oe_o(pad_oe_o[p]), .in_req_o(in_req[p])
    );
  end

  pinmux_in_arb #(
    .NUM_PINS(NUM_PINS), .NUM_IN(NUM_IN), .IN_IDLE(IN_IDLE)
  ) u_arb (
    .req_i(in_req), .pad_in_i, .per_in_o
  );

  assign swd_clk_o  = lock & pad_in_i[DBG_CLK_PIN];
  assign swd_dio_o  = lock ? pad_in_i[DBG_DAT_PIN] : 1'b1;
  assign dbg_lock_o = lock;
endmodule

// File: rtl/pinmux_xbar_chk.sv
module pinmux_xbar_chk #(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned FID_W       = 6,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DBG_CLK_PIN = 6,
  parameter int unsigned DBG_DAT_PIN = 7
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           wr_en_i,
  input logic [ADDR_W-1:0]              wr_addr_i,
  input logic [FID_W-1:0]               wr_data_i,
  input logic [NUM_PINS-1:0]            pad_out_o,
  input logic [NUM_PINS-1:0]            pad_oe_o,
  input logic                           swd_dio_i,
  input logic                           swd_dio_oe_i,
  input logic                           dbg_lock_o,
  input logic                           dbg_taken_o,
  input logic [NUM_PINS-1:0][FID_W-1:0] fid_q
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_PINS);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
    p_oe_gates_out_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pad_oe_o[p] |-> !pad_out_o[p]);
  end

  p_dat_follows_dbg_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_lock_o |-> (pad_oe_o[DBG_DAT_PIN] == swd_dio_oe_i) &&
                   (pad_out_o[DBG_DAT_PIN] == (swd_dio_i & swd_dio_oe_i)));

  p_clk_pin_input_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_lock_o |-> !pad_oe_o[DBG_CLK_PIN]);

  p_locked_wr_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_lock_o && wr_en_i &&
    (wr_addr_i == ADDR_W'(DBG_CLK_PIN) || wr_addr_i == ADDR_W'(DBG_DAT_PIN))
    |=> $stable(fid_q[DBG_CLK_PIN]) && $stable(fid_q[DBG_DAT_PIN]));

  p_ctrl_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i == CTRL_ADDR |=> dbg_lock_o == $past(wr_data_i[0]));

  p_taken_needs_unlock_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_taken_o |-> !dbg_lock_o);

  p_relock_clears_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i == CTRL_ADDR && wr_data_i[0] |=> !dbg_taken_o);

  p_high_addr_ignored_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i > CTRL_ADDR |=> $stable(fid_q) && $stable(dbg_lock_o));
endmodule

bind pinmux_xbar pinmux_xbar_chk #(
  .NUM_PINS(NUM_PINS), .FID_W(FID_W), .ADDR_W(ADDR_W),
  .DBG_CLK_PIN(DBG_CLK_PIN), .DBG_DAT_PIN(DBG_DAT_PIN)
) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .pad_out_o, .pad_oe_o,
  .swd_dio_i, .swd_dio_oe_i, .dbg_lock_o, .dbg_taken_o, .fid_q
);

// File: tb/pinmux_xbar_tb.sv
module pinmux_xbar_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0] pin;
    logic [5:0] fid;
    logic [7:0] pad;
    logic [3:0] pout;
    logic [3:0] poe;
    logic       eout;
    logic       eoe;
    logic [3:0] ein;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 6'd0,  8'hFF, 4'hF,    4'hF,    1'b0, 1'b0, 4'b0011}, // R2
    '{3'd0, 6'd1,  8'h00, 4'hF,    4'hF,    1'b0, 1'b0, 4'b0010}, // R3
    '{3'd1, 6'd1,  8'h00, 4'h0,    4'h0,    1'b0, 1'b0, 4'b0001}, // R3
    '{3'd5, 6'd1,  8'hDF, 4'h0,    4'h0,    1'b0, 1'b0, 4'b0001}, // R3 wrap
    '{3'd2, 6'd2,  8'h00, 4'b0100, 4'b0100, 1'b1, 1'b1, 4'b0011}, // R4
    '{3'd3, 6'd2,  8'h00, 4'b0000, 4'b1000, 1'b0, 1'b1, 4'b0011}, // R4
    '{3'd4, 6'd2,  8'h00, 4'b0001, 4'b0000, 1'b0, 1'b0, 4'b0011}, // R4 R9
    '{3'd0, 6'd19, 8'h00, 4'b1000, 4'b1000, 1'b1, 1'b1, 4'b0011}, // R5
    '{3'd3, 6'd16, 8'h00, 4'b0001, 4'b0001, 1'b1, 1'b1, 4'b0011}, // R5
    '{3'd2, 6'd20, 8'h00, 4'h0,    4'h0,    1'b0, 1'b0, 4'b0010}, // R6
    '{3'd4, 6'd23, 8'h10, 4'h0,    4'h0,    1'b0, 1'b0, 4'b1011}, // R6
    '{3'd5, 6'd22, 8'h20, 4'h0,    4'h0,    1'b0, 1'b0, 4'b0111}, // R6
    '{3'd1, 6'd3,  8'hFF, 4'hF,    4'hF,    1'b0, 1'b0, 4'b0011}, // R2
    '{3'd1, 6'd24, 8'hFF, 4'hF,    4'hF,    1'b0, 1'b0, 4'b0011}, // R2
    '{3'd2, 6'd63, 8'hFF, 4'hF,    4'hF,    1'b0, 1'b0, 4'b0011}, // R2
    '{3'd4, 6'd20, 8'hEF, 4'hF,    4'hF,    1'b0, 1'b0, 4'b0010}  // R6
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [5:0] wr_data = '0;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe;
  logic [3:0] per_out = '0, per_oe = '0, per_in;
  logic       swd_dio = 1'b0, swd_dio_oe = 1'b0;
  logic       swd_clk, swd_dio_in, lock, taken, taken_pin;
  logic [5:0] taken_fid;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pinmux_xbar u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pad_in_i(pad_in), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe), .per_out_i(per_out), .per_oe_i(per_oe),
    .per_in_o(per_in), .swd_dio_i(swd_dio), .swd_dio_oe_i(swd_dio_oe),
    .swd_clk_o(swd_clk), .swd_dio_o(swd_dio_in), .dbg_lock_o(lock),
    .dbg_taken_o(taken), .dbg_taken_pin_o(taken_pin),
    .dbg_taken_fid_o(taken_fid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [5:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 oe", 32'(pad_oe), 32'h0);
    chk("R1 per_in", 32'(per_in), 32'b0011);
    chk("R1 lock", 32'(lock), 32'd1);
    chk("R1 taken", 32'(taken), 32'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R7 idle", 32'(per_in), 32'b0011);

    // vector walk
    for (int v = 0; v < NV; v++) begin
      pad_in = VECS[v].pad; per_out = VECS[v].pout; per_oe = VECS[v].poe;
      wr({1'b0, VECS[v].pin}, VECS[v].fid);
      chk($sformatf("R2-6 vec%0d out", v), 32'(pad_out[VECS[v].pin]), 32'(VECS[v].eout));
      chk($sformatf("R2-6 vec%0d oe", v), 32'(pad_oe[VECS[v].pin]), 32'(VECS[v].eoe));
      chk($sformatf("R2-6 vec%0d in", v), 32'(per_in), 32'(VECS[v].ein));
      wr({1'b0, VECS[v].pin}, 6'd0);
    end

    // R13 timing: no effect in the write cycle itself
    per_out = 4'b1000; per_oe = 4'b1000;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = 6'd19;
    #1 chk("R13 before edge", 32'(pad_oe[0]), 32'd0);
    @(negedge clk); wr_en = 1'b0; #1;
    chk("R13 after edge", 32'(pad_oe[0]), 32'd1);
    wr(4'd0, 6'd0);

    // R8 priority
    wr(4'd1, 6'd21); wr(4'd4, 6'd21);
    pad_in = 8'h10; #1;
    chk("R8 low pin wins 0", 32'(per_in[1]), 32'd0);
    pad_in = 8'h02; #1;
    chk("R8 low pin wins 1", 32'(per_in[1]), 32'd1);
    wr(4'd1, 6'd0); pad_in = 8'h10; #1;
    chk("R8 next pin", 32'(per_in[1]), 32'd1);
    wr(4'd1, 6'd1); pad_in = 8'h10; #1;
    chk("R8 dedicated vs crossbar", 32'(per_in[1]), 32'd0);
    wr(4'd1, 6'd0); wr(4'd4, 6'd0);

    // R10 locked debug pins
    wr(4'd7, 6'd19);
    swd_dio = 1'b1; swd_dio_oe = 1'b1; pad_in = 8'h40; #1;
    chk("R10 dat oe", 32'(pad_oe[7]), 32'd1);
    chk("R10 dat out", 32'(pad_out[7]), 32'd1);
    chk("R10 clk in", 32'(swd_clk), 32'd1);
    chk("R10 dio in", 32'(swd_dio_in), 32'd0);
    swd_dio_oe = 1'b0; #1;
    chk("R10 dat oe off", 32'(pad_oe[7]), 32'd0);
    chk("R10 no taken", 32'(taken), 32'd0);

    // R11 unlock
    wr(4'd8, 6'd0);
    chk("R11 lock", 32'(lock), 32'd0);
    chk("R11 clk idle", 32'(swd_clk), 32'd0);
    chk("R11 dio idle", 32'(swd_dio_in), 32'd1);
    swd_dio_oe = 1'b1; #1;
    chk("R11 fid kept 0", 32'(pad_oe[7]), 32'd0);
    wr(4'd7, 6'd19);
    chk("R11 remapped", 32'(pad_out[7]), 32'd1);
    chk("R12 taken", 32'(taken), 32'd1);
    chk("R12 pin", 32'(taken_pin), 32'd1);
    chk("R12 fid", 32'(taken_fid), 32'd19);
    pad_in = 8'h00;
    wr(4'd6, 6'd20);
    chk("R12 pin clk", 32'(taken_pin), 32'd0);
    chk("R12 fid 20", 32'(taken_fid), 32'd20);
    chk("R11 pin6 feeds in0", 32'(per_in[0]), 32'd0);

    // R13 high address
    wr(4'd12, 6'd1);
    chk("R13 lock kept", 32'(lock), 32'd0);
    chk("R13 pins kept", 32'(pad_out[7]), 32'd1);

    // relock
    swd_dio = 1'b0;
    wr(4'd8, 6'd1);
    chk("R12 cleared", 32'(taken), 32'd0);
    chk("R11 relock dat", 32'(pad_out[7]), 32'd0);
    chk("R11 relock in0 idle", 32'(per_in[0]), 32'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule